// File: doc/BRIEF.md
# Two-Speed Start-Up Clock Switcher

This block lets a system run at once from an internal oscillator while a slow crystal-type external oscillator is still settling. At power-up or wake it gives the system clock to the internal source. In the two crystal modes it counts a fixed number of external clock cycles as a stabilisation interval. It then moves the system clock to the external source. The move happens on a falling edge of the internal clock, and the output is held low until the external side takes over on one of its own falling edges, so no short pulse can reach the clock tree.

Mode is a 2-bit configuration input. In the external-clock-input mode no stabilisation is needed and the handover starts as soon as the sequence starts. In the internal-only mode the external source is never selected. A wake pulse or a reset restarts the whole sequence from the internal clock. All signals that cross between the two clock domains pass through multi-flop synchronisers.

Top module: `twospeed_clk_switch`

## Requirements
- R1: While `rst_n` is low, `start_done_o` and `sel_ext_o` are 0 and `sys_clk_o` follows `clk_int`.
- R2: In mode 00 (low-power crystal) and mode 01 (standard crystal), `start_done_o` rises no earlier than OST_CYCLES (default 1024) rising edges of `clk_ext` after the start event. The start event is a rise of `pwrt_done_i`, a wake pulse, or a reset release with `pwrt_done_i` already high. The rise comes no later than OST_CYCLES+12 such edges.
- R3: `start_done_o` only rises at a falling edge of `clk_int`, and only after the handover has been requested.
- R4: From the rise of `start_done_o`, `sys_clk_o` stays low until at least one falling edge of `clk_ext` has passed.
- R5: While `sel_ext_o` is 1, `sys_clk_o` equals `clk_ext`. `sel_ext_o` is high within 20 `clk_ext` cycles after the latest time `start_done_o` is due.
- R6: In mode 10 (external clock input) there is no count, and `start_done_o` rises within 12 `clk_ext` cycles of the start event.
- R7: In mode 11 (internal only), `start_done_o` and `sel_ext_o` stay 0 and `sys_clk_o` keeps following `clk_int`.
- R8: `wake_i` is a one-cycle pulse sampled on a rising edge of `clk_int`. It clears `start_done_o` by the next falling edge of `clk_int`. It returns `sys_clk_o` to `clk_int` with `sel_ext_o` low within 10 `clk_ext` cycles. It then runs a fresh sequence, including a full count in crystal modes.
- R9: While `pwrt_done_i` is 0 no sequence starts: `start_done_o` stays 0 and `sys_clk_o` follows `clk_int`.
- R10: The internal and external paths are never enabled together. `sys_clk_o` never shows a phase shorter than half the period of the faster input clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_int | input | 1 | Internal oscillator clock |
| clk_ext | input | 1 | External oscillator clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| wake_i | input | 1 | Wake-from-sleep pulse, synchronous to clk_int |
| pwrt_done_i | input | 1 | Power-up timer finished (tie high when that timer is off) |
| osc_mode_i | input | 2 | 00 low-power crystal, 01 standard crystal, 10 external clock input, 11 internal only |
| sys_clk_o | output | 1 | Glitch-free system clock |
| start_done_o | output | 1 | Stabilisation finished and handover taken on an internal falling edge |
| sel_ext_o | output | 1 | System clock currently driven by clk_ext |

## Verification
The flag is due after the count, two synchroniser stages each way, one controller register and one internal falling edge. The bench therefore expects it in a window: never before OST_CYCLES external edges after the start event, and always by 12 edges past that. Selection of the external path needs two more external falling-edge stages plus one enable register, so the select check allows 20 external cycles. The return to the internal clock after wake allows 10. Outputs are sampled 1 ns after each rising edge and 1 ns after each falling edge of the internal clock. Those instants fall clear of every edge of both clocks, and each sample is compared with a behavioural model that counts external edges since the last start event. Edge-exact properties are measured directly from event times: the level of `clk_int` when the flag rises, an external falling edge before the first external-driven rise, and the minimum phase width.

// File: rtl/tss_pkg.sv
package tss_pkg;

   typedef enum logic [1:0] {
      OSC_LP_XTAL  = 2'b00,
      OSC_STD_XTAL = 2'b01,
      OSC_EXT_IN   = 2'b10,
      OSC_INT_ONLY = 2'b11
   } osc_mode_e;

   typedef enum logic [1:0] {
      SEQ_IDLE   = 2'b00,
      SEQ_COUNT  = 2'b01,
      SEQ_SWITCH = 2'b10
   } seq_state_e;

   function automatic logic mode_needs_settle(input osc_mode_e m);
      return (m == OSC_LP_XTAL) || (m == OSC_STD_XTAL);
   endfunction

   function automatic logic mode_uses_ext(input osc_mode_e m);
      return m != OSC_INT_ONLY;
   endfunction

endpackage

// File: rtl/tss_sync.sv
module tss_sync #(
   parameter int STAGES   = 2,
   parameter bit NEG_EDGE = 1'b0,
   parameter bit RST_VAL  = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   localparam int LAST = STAGES - 1;

   logic [LAST:0] chain;

   initial begin : param_check
      if (STAGES < 2) $fatal(1, "tss_sync needs at least two stages");
   end

   generate
      if (NEG_EDGE) begin : g_fall
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL}};
            else        chain <= {chain[LAST-1:0], d_i};
         end
      end else begin : g_rise
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL}};
            else        chain <= {chain[LAST-1:0], d_i};
         end
      end
   endgenerate

   assign q_o = chain[LAST];
endmodule

// File: rtl/tss_ost_counter.sv
module tss_ost_counter #(
   parameter int CYCLES = 1024,
   localparam int CW = $clog2(CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic done_o
);
   localparam logic [CW-1:0] LAST_CNT = CW'(CYCLES - 1);

   logic [CW-1:0] cnt_q;

   initial begin : param_check
      if (CYCLES < 2) $fatal(1, "tss_ost_counter needs CYCLES >= 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         done_o <= 1'b0;
      end else if (!run_i) begin
         cnt_q  <= '0;
         done_o <= 1'b0;
      end else if (!done_o) begin
         cnt_q <= cnt_q + CW'(1);
         if (cnt_q == LAST_CNT) done_o <= 1'b1;
      end
   end
endmodule

// File: rtl/tss_seq_ctrl.sv
module tss_seq_ctrl
   import tss_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      wake_i,
   input  logic      pwrt_done_i,
   input  osc_mode_e mode_i,
   input  logic      settled_i,
   output logic      cnt_req_o,
   output logic      want_ext_o
);
   seq_state_e state_q, state_d;
   logic       xtal_q, xtal_d;

   always_comb begin
      state_d = state_q;
      xtal_d  = xtal_q;
      if (wake_i) begin
         state_d = SEQ_IDLE;
      end else begin
         unique case (state_q)
            SEQ_IDLE: begin
               xtal_d = mode_needs_settle(mode_i);
               if (pwrt_done_i && !settled_i && mode_uses_ext(mode_i)) begin
                  state_d = mode_needs_settle(mode_i) ? SEQ_COUNT : SEQ_SWITCH;
               end
            end
            SEQ_COUNT: begin
               if (settled_i) state_d = SEQ_SWITCH;
            end
            SEQ_SWITCH: state_d = SEQ_SWITCH;
            default:    state_d = SEQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= SEQ_IDLE;
         xtal_q     <= 1'b0;
         cnt_req_o  <= 1'b0;
         want_ext_o <= 1'b0;
      end else begin
         state_q    <= state_d;
         xtal_q     <= xtal_d;
         cnt_req_o  <= (state_d != SEQ_IDLE) && xtal_d;
         want_ext_o <= (state_d == SEQ_SWITCH);
      end
   end
endmodule

// File: rtl/tss_glitchless_mux.sv
module tss_glitchless_mux #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_int,
   input  logic clk_ext,
   input  logic rst_n,
   input  logic want_ext_i,
   output logic sys_clk_o,
   output logic int_en_o,
   output logic ext_en_o
);
   logic want_ext_x;
   logic int_on_x;
   logic ext_on_i;

   tss_sync #(.STAGES(SYNC_STAGES), .NEG_EDGE(1'b1), .RST_VAL(1'b0)) u_want_to_ext (
      .clk(clk_ext), .rst_n(rst_n), .d_i(want_ext_i), .q_o(want_ext_x)
   );

   tss_sync #(.STAGES(SYNC_STAGES), .NEG_EDGE(1'b1), .RST_VAL(1'b1)) u_int_to_ext (
      .clk(clk_ext), .rst_n(rst_n), .d_i(int_en_o), .q_o(int_on_x)
   );

   tss_sync #(.STAGES(SYNC_STAGES), .NEG_EDGE(1'b1), .RST_VAL(1'b0)) u_ext_to_int (
      .clk(clk_int), .rst_n(rst_n), .d_i(ext_en_o), .q_o(ext_on_i)
   );

   always_ff @(negedge clk_int or negedge rst_n) begin
      if (!rst_n) int_en_o <= 1'b1;
      else        int_en_o <= !want_ext_i && !ext_on_i;
   end

   always_ff @(negedge clk_ext or negedge rst_n) begin
      if (!rst_n) ext_en_o <= 1'b0;
      else        ext_en_o <= want_ext_x && !int_on_x;
   end

   assign sys_clk_o = (clk_int & int_en_o) | (clk_ext & ext_en_o);
endmodule

// File: rtl/twospeed_clk_switch.sv
module twospeed_clk_switch
   import tss_pkg::*;
#(
   parameter int OST_CYCLES  = 1024,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk_int,
   input  logic       clk_ext,
   input  logic       rst_n,
   input  logic       wake_i,
   input  logic       pwrt_done_i,
   input  logic [1:0] osc_mode_i,
   output logic       sys_clk_o,
   output logic       start_done_o,
   output logic       sel_ext_o
);
   logic cnt_req;
   logic cnt_run_x;
   logic ost_done_x;
   logic ost_done_s;
   logic want_ext;
   logic int_en;
   logic ext_en;

   initial begin : param_check
      if (SYNC_STAGES < 2) $fatal(1, "SYNC_STAGES must be at least 2");
      if (OST_CYCLES < 2)  $fatal(1, "OST_CYCLES must be at least 2");
   end

   tss_sync #(.STAGES(SYNC_STAGES), .NEG_EDGE(1'b0), .RST_VAL(1'b0)) u_req_sync (
      .clk(clk_ext), .rst_n(rst_n), .d_i(cnt_req), .q_o(cnt_run_x)
   );

   tss_ost_counter #(.CYCLES(OST_CYCLES)) u_ost (
      .clk(clk_ext), .rst_n(rst_n), .run_i(cnt_run_x), .done_o(ost_done_x)
   );

   tss_sync #(.STAGES(SYNC_STAGES), .NEG_EDGE(1'b0), .RST_VAL(1'b0)) u_done_sync (
      .clk(clk_int), .rst_n(rst_n), .d_i(ost_done_x), .q_o(ost_done_s)
   );

   tss_seq_ctrl u_ctrl (
      .clk        (clk_int),
      .rst_n      (rst_n),
      .wake_i     (wake_i),
      .pwrt_done_i(pwrt_done_i),
      .mode_i     (osc_mode_e'(osc_mode_i)),
      .settled_i  (ost_done_s),
      .cnt_req_o  (cnt_req),
      .want_ext_o (want_ext)
   );

   tss_glitchless_mux #(.SYNC_STAGES(SYNC_STAGES)) u_mux (
      .clk_int   (clk_int),
      .clk_ext   (clk_ext),
      .rst_n     (rst_n),
      .want_ext_i(want_ext),
      .sys_clk_o (sys_clk_o),
      .int_en_o  (int_en),
      .ext_en_o  (ext_en)
   );

   always_ff @(negedge clk_int or negedge rst_n) begin
      if (!rst_n) start_done_o <= 1'b0;
      else        start_done_o <= want_ext;
   end

   assign sel_ext_o = ext_en;
endmodule

// File: rtl/tss_checker.sv
module tss_checker (
   input logic       clk_int,
   input logic       clk_ext,
   input logic       rst_n,
   input logic       wake_i,
   input logic       pwrt_done_i,
   input logic [1:0] osc_mode_i,
   input logic       start_done_o,
   input logic       int_en,
   input logic       ext_en,
   input logic       want_ext,
   input logic       cnt_req,
   input logic       ost_done_s
);
   AST_SINGLE_SOURCE: assert property (@(posedge clk_int) disable iff (!rst_n)
      !(int_en && ext_en)) else $error("both clock paths enabled"); // R10

   AST_EXT_AFTER_INT_OFF: assert property (@(posedge clk_ext) disable iff (!rst_n)
      $rose(ext_en) |-> !int_en) else $error("external path on before internal off"); // R4

   AST_DONE_NEEDS_COUNT: assert property (@(posedge clk_int) disable iff (!rst_n)
      (start_done_o && cnt_req) |-> ost_done_s) else $error("flag without count"); // R2

   AST_WAKE_DROPS_REQ: assert property (@(posedge clk_int) disable iff (!rst_n)
      wake_i |=> (!want_ext && !cnt_req)) else $error("wake did not restart"); // R8

   AST_START_NEEDS_PWRT: assert property (@(posedge clk_int) disable iff (!rst_n)
      ($rose(cnt_req) || $rose(want_ext)) |-> $past(pwrt_done_i)) else $error("start without timer"); // R9

   AST_INT_ONLY_STAYS: assert property (@(posedge clk_int) disable iff (!rst_n)
      (osc_mode_i == 2'b11 && !want_ext) |=> !want_ext) else $error("internal-only left internal"); // R7

   AST_DONE_AFTER_REQ: assert property (@(posedge clk_int) disable iff (!rst_n)
      $rose(start_done_o) |-> want_ext) else $error("flag without handover request"); // R3
endmodule

bind twospeed_clk_switch tss_checker u_tss_checker (
   .clk_int     (clk_int),
   .clk_ext     (clk_ext),
   .rst_n       (rst_n),
   .wake_i      (wake_i),
   .pwrt_done_i (pwrt_done_i),
   .osc_mode_i  (osc_mode_i),
   .start_done_o(start_done_o),
   .int_en      (int_en),
   .ext_en      (ext_en),
   .want_ext    (want_ext),
   .cnt_req     (cnt_req),
   .ost_done_s  (ost_done_s)
);

// File: tb/test_twospeed_clk_switch.sv
module test_twospeed_clk_switch;
   localparam int OST       = 1024;
   localparam int SLACK     = 12;
   localparam int SEL_SLACK = 20;
   localparam int SETTLE    = 10;

   logic       clk_int = 1'b0;
   logic       clk_ext = 1'b0;
   logic       rst_n = 1'b0;
   logic       wake_i = 1'b0;
   logic       pwrt_done_i = 1'b0;
   logic [1:0] osc_mode_i = 2'b00;
   logic       sys_clk_o;
   logic       start_done_o;
   logic       sel_ext_o;

   twospeed_clk_switch #(.OST_CYCLES(OST), .SYNC_STAGES(2)) i_twospeed_clk_switch (
      .clk_int(clk_int), .clk_ext(clk_ext), .rst_n(rst_n), .wake_i(wake_i),
      .pwrt_done_i(pwrt_done_i), .osc_mode_i(osc_mode_i),
      .sys_clk_o(sys_clk_o), .start_done_o(start_done_o), .sel_ext_o(sel_ext_o)
   );

   always #5 clk_int = ~clk_int;
   initial begin
      #7;
      forever begin
         clk_ext = ~clk_ext;
         #15;
      end
   end

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   task automatic check(input bit ok, input string tag, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   // reference model state
   int ext_total = 0, int_total = 0, ext_base = 0, int_base = 0;
   logic [1:0] m_mode = 2'b00;
   bit         m_pwrt = 1'b0;
   always @(posedge clk_ext) ext_total++;
   always @(posedge clk_int) int_total++;

   task automatic restart();
      ext_base = ext_total;
      int_base = int_total;
   endtask

   task automatic model_check();
      int  es, is, off;
      bit  active, xtal, low_zone;
      string tag;
      if (!rst_n) return;
      es = ext_total - ext_base;
      is = int_total - int_base;
      xtal = (m_mode == 2'b00) || (m_mode == 2'b01);
      active = m_pwrt && (m_mode != 2'b11);
      off = xtal ? OST : 0;
      low_zone = !active || (xtal && es < OST);
      tag = !m_pwrt ? "R9" : (m_mode == 2'b11 ? "R7" : "R2");
      if (is >= 2 && low_zone)
         check(start_done_o == 1'b0, tag, "flag low before settle", start_done_o, 0);
      if (is >= 2 && es >= SETTLE && low_zone) begin
         check(sel_ext_o == 1'b0, tag, "select low before settle", sel_ext_o, 0);
         check(sys_clk_o == clk_int, "R8", "system clock follows internal", sys_clk_o, clk_int);
      end
      if (active && es > off + SLACK)
         check(start_done_o == 1'b1, xtal ? "R2" : "R6", "flag high by deadline", start_done_o, 1);
      if (active && es > off + SLACK + SEL_SLACK)
         check(sel_ext_o == 1'b1, "R5", "select high by deadline", sel_ext_o, 1);
      if (sel_ext_o)
         check(sys_clk_o == clk_ext, "R5", "system clock follows external", sys_clk_o, clk_ext);
   endtask

   always @(posedge clk_int) begin
      #1;
      model_check();
      #5;
      model_check();
   end

   // edge-event recorders
   realtime t_done = -1.0, t_rise = -1.0, t_ext_neg = -1.0, t_edge = -1.0;
   int      done_es = 0;
   bit      done_lvl = 1'b0;
   bit      neg_seen = 1'b0;
   int      glitch_n = 0;

   always @(negedge clk_ext) t_ext_neg = $realtime;
   always @(posedge start_done_o) begin
      t_done   = $realtime;
      done_es  = ext_total - ext_base;
      done_lvl = clk_int;
   end
   always @(posedge sys_clk_o) begin
      if (t_done >= 0.0 && t_rise < t_done) begin
         t_rise   = $realtime;
         neg_seen = (t_ext_neg > t_done);
      end
   end
   always @(sys_clk_o) begin
      if (!rst_n) t_edge = -1.0;
      else begin
         if (t_edge >= 0.0 && ($realtime - t_edge) < 5.0) glitch_n++;   // R10
         t_edge = $realtime;
      end
   end

   task automatic check_reset_state();
      @(posedge clk_int); #1;
      check(start_done_o == 1'b0, "R1", "flag in reset", start_done_o, 0);
      check(sel_ext_o == 1'b0, "R1", "select in reset", sel_ext_o, 0);
      check(sys_clk_o == clk_int, "R1", "clock in reset (high phase)", sys_clk_o, clk_int);
      #5;
      check(sys_clk_o == clk_int, "R1", "clock in reset (low phase)", sys_clk_o, clk_int);
   endtask

   task automatic do_reset(input logic [1:0] mode);
      @(posedge clk_int); #2;
      rst_n = 1'b0; pwrt_done_i = 1'b0; osc_mode_i = mode;
      m_mode = mode; m_pwrt = 1'b0;
      repeat (3) check_reset_state();
      @(posedge clk_int); #2;
      rst_n = 1'b1;
      restart();
   endtask

   task automatic raise_pwrt();
      @(posedge clk_int); #2;
      pwrt_done_i = 1'b1; m_pwrt = 1'b1;
      restart();
   endtask

   task automatic pulse_wake(input logic [1:0] mode);
      @(posedge clk_int); #2;
      wake_i = 1'b1; osc_mode_i = mode; m_mode = mode;
      restart();
      @(posedge clk_int); #2;
      wake_i = 1'b0;
      @(negedge clk_int); #1;
      check(start_done_o == 1'b0, "R8", "flag cleared after wake", start_done_o, 0);
   endtask

   task automatic wait_done(input string tag, input int lo, input int hi);
      int n;
      n = 0;
      while (!start_done_o && n < (OST + 200) * 4) begin @(posedge clk_int); n++; end
      #1;
      check(start_done_o == 1'b1, tag, "flag reached", start_done_o, 1);
      check(done_es >= lo && done_es <= hi, tag, "external edges at flag rise", done_es, lo);
      check(done_lvl == 1'b0, "R3", "internal clock level at flag rise", done_lvl, 0);
      n = 0;
      while (t_rise < t_done && n < 400) begin @(posedge clk_int); n++; end
      check(neg_seen == 1'b1, "R4", "external falling edge before first rise", neg_seen, 1);
      n = 0;
      while (!sel_ext_o && n < 400) begin @(posedge clk_int); n++; end
      check(sel_ext_o == 1'b1, "R5", "external selected", sel_ext_o, 1);
   endtask

   task automatic run_ext(input int n);
      repeat (n) @(posedge clk_ext);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #1_500_000;
      check(1'b0, "WATCHDOG", "run did not complete", 0, 1);
      finish_run();
   end

   initial begin
      // R1 and R9: reset, then wait with the power-up timer still running
      do_reset(2'b00);
      run_ext(120);
      check(start_done_o == 1'b0, "R9", "no start without timer", start_done_o, 0);
      // R2: low-power crystal full sequence
      raise_pwrt();
      wait_done("R2", OST, OST + SLACK);
      run_ext(150);
      // R8: wake into standard crystal, fresh full count
      pulse_wake(2'b01);
      wait_done("R8", OST, OST + SLACK);
      run_ext(150);
      // R6: external clock input mode skips the count
      do_reset(2'b10);
      run_ext(20);
      raise_pwrt();
      wait_done("R6", 0, SLACK);
      run_ext(100);
      // R7: wake into internal-only mode
      pulse_wake(2'b11);
      run_ext(1200);
      check(start_done_o == 1'b0, "R7", "internal-only flag", start_done_o, 0);
      check(sel_ext_o == 1'b0, "R7", "internal-only select", sel_ext_o, 0);
      // R8: wake back into a crystal mode from internal-only
      pulse_wake(2'b00);
      wait_done("R8", OST, OST + SLACK);
      run_ext(100);
      check(glitch_n == 0, "R10", "short clock phases", glitch_n, 0);
      finish_run();
   end
endmodule